// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that measures elapsed time in ticks of an always-on, low-speed oscillator. Those ticks arrive as a one-cycle enable on `osc_tick_i`, which is independent of the gated CPU clock. Each tick steps an 8-bit prescaler. A 3-bit select picks one tap of the prescaler, and that tap advances the watchdog counter. When the counter reaches its terminal value while the watchdog is enabled, the block emits a one-cycle reset request and restarts from zero.

Software uses a small write port. One strobe carries an enable bit, the prescale code and a clear request, which is the "kick". Counting goes on while `sleep_i` is high, so a watchdog left enabled before sleep can still reset the device out of sleep. While `sleep_i` is high, configuration writes are ignored, but the clear request is still honoured.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset `rst_req_o` and `timeout_o` are low, the watchdog is enabled (parameter `EN_RST`=1) and the prescale code is 0.
- R2: With prescale code 0 and the watchdog enabled, `rst_req_o` rises in the cycle after the BASE_TICKS-th `osc_tick_i` counted from the last restart.
- R3: Prescale code c (0..7, written through `wr_sel_i`) stretches the period to BASE_TICKS·2^c ticks, because the counter advances only on ticks where the low c prescaler bits are all ones.
- R4: `rst_req_o` is high for exactly one cycle. Prescaler and counter then restart from zero, so the next request follows a full period later.
- R5: Ticks are counted, and requests are issued, whether `sleep_i` is high or low.
- R6: A write with `wr_kick_i`=1 clears the prescaler, the counter and `timeout_o`, in sleep or not. A kick on the same cycle as an expiry suppresses that request.
- R7: While disabled, no request is issued and both counters are held at zero. After re-enabling, a full period is needed.
- R8: While `sleep_i` is high, writes to the enable bit and the prescale code have no effect.
- R9: `timeout_o` is set by an expiry and stays high until a kick.
- R10: Cycles without `osc_tick_i` do not advance the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on clock domain of the watchdog |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | One-cycle tick from the low-speed oscillator |
| sleep_i | input | 1 | Device is in sleep; config writes are blocked |
| wr_en_i | input | 1 | Write strobe for the fields below |
| wr_on_i | input | 1 | New enable bit |
| wr_sel_i | input | 3 | New prescale code (divide by 2^code) |
| wr_kick_i | input | 1 | Clear request (kick) |
| timeout_o | output | 1 | Sticky expiry flag, cleared by kick |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The period is exercised with dense ticks, ticks on every third cycle only, and long gaps. This separates counting osc ticks from counting clock cycles. Codes 0, 3 and 7 are each run through two expiries, which shows that the tap selection scales the period and that the restart is clean. Kicks placed just before and exactly on an expiry tell a cleared count apart from a suppressed request. Writes made under sleep, compared with the same writes made awake, show whether the write block is applied.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned PSEL_W = 3;
   typedef struct packed {
      logic              on;
      logic [PSEL_W-1:0] sel;
   } wdt_cfg_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
   import wdt_pkg::*;
#(
   parameter bit EN_RST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sleep_i,
   input  logic              wr_en_i,
   input  logic              wr_on_i,
   input  logic [PSEL_W-1:0] wr_sel_i,
   output wdt_cfg_t          cfg_o
);
   wdt_cfg_t cfg_q;
   logic     cfg_wr;

   assign cfg_wr = wr_en_i & ~sleep_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q.on  <= EN_RST;
         cfg_q.sel <= '0;
      end else if (cfg_wr) begin
         cfg_q.on  <= wr_on_i;
         cfg_q.sel <= wr_sel_i;
      end
   end

   assign cfg_o = cfg_q;

   AST_SLEEP_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_i && wr_en_i) |=> (cfg_o == $past(cfg_o))); // R8
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned PRE_W = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic             osc_tick_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o,
   output logic [PRE_W-1:0] pre_o
);
   localparam int unsigned NTAP = 1 << SEL_W;

   logic [PRE_W-1:0] pre_q;
   logic [NTAP-1:0]  tap;

   generate
      if (PRE_W + 1 < NTAP) begin : g_bad_width
         $error("prescaler too narrow for select width");
      end
      for (genvar i = 0; i < NTAP; i++) begin : g_tap
         if (i == 0) begin : g_unscaled
            assign tap[i] = 1'b1;
         end else begin : g_scaled
            assign tap[i] = &pre_q[i-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pre_q <= '0;
      else if (clr_i)             pre_q <= '0;
      else if (run_i & osc_tick_i) pre_q <= pre_q + 1'b1;
   end

   assign tick_o = run_i & osc_tick_i & tap[sel_i];
   assign pre_o  = pre_q;

   AST_PRE_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!osc_tick_i && !clr_i) |=> (pre_o == $past(pre_o))); // R10
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned BASE_TICKS = 18,
   parameter int unsigned CNT_W      = $clog2(BASE_TICKS + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             tick_i,
   output logic             last_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (BASE_TICKS < 2) begin : g_bad_base
         $error("BASE_TICKS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cnt_q <= '0;
      else if (clr_i)                 cnt_q <= '0;
      else if (tick_i && cnt_q == LAST) cnt_q <= '0;
      else if (tick_i)                cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = tick_i && (cnt_q == LAST);
   assign cnt_o  = cnt_q;

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_o <= LAST); // R2
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
   import wdt_pkg::*;
#(
   parameter int unsigned BASE_TICKS = 18,
   parameter int unsigned PRE_W      = 8,
   parameter bit          EN_RST     = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              osc_tick_i,
   input  logic              sleep_i,
   input  logic              wr_en_i,
   input  logic              wr_on_i,
   input  logic [PSEL_W-1:0] wr_sel_i,
   input  logic              wr_kick_i,
   output logic              timeout_o,
   output logic              rst_req_o
);
   localparam int unsigned CNT_W = $clog2(BASE_TICKS + 1);

   wdt_cfg_t         cfg;
   logic             kick, clr, wd_tick, last, fire;
   logic [PRE_W-1:0] pre;
   logic [CNT_W-1:0] cnt;
   logic             req_q, tmo_q;

   assign kick = wr_en_i & wr_kick_i;

   wdt_ctrl #(.EN_RST(EN_RST)) i_ctrl (
      .clk_i, .rst_ni, .sleep_i, .wr_en_i, .wr_on_i, .wr_sel_i, .cfg_o(cfg)
   );

   assign fire = last & cfg.on & ~kick;
   assign clr  = kick | ~cfg.on | fire;

   wdt_prescaler #(.PRE_W(PRE_W), .SEL_W(PSEL_W)) i_pre (
      .clk_i, .rst_ni, .run_i(cfg.on), .clr_i(clr), .osc_tick_i,
      .sel_i(cfg.sel), .tick_o(wd_tick), .pre_o(pre)
   );

   wdt_counter #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) i_cnt (
      .clk_i, .rst_ni, .clr_i(kick | ~cfg.on), .tick_i(wd_tick),
      .last_o(last), .cnt_o(cnt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q <= 1'b0;
         tmo_q <= 1'b0;
      end else begin
         req_q <= fire;
         if (kick)      tmo_q <= 1'b0;
         else if (fire) tmo_q <= 1'b1;
      end
   end

   assign rst_req_o = req_q;
   assign timeout_o = tmo_q;

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |=> !rst_req_o); // R4
   AST_REQ_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> (cnt == '0 && pre == '0 && timeout_o)); // R4
   AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kick |=> (cnt == '0 && pre == '0 && !rst_req_o && !timeout_o)); // R6
   AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg.on |=> (!rst_req_o && cnt == '0)); // R7
   AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timeout_o && !kick) |=> timeout_o); // R9
endmodule

// File: tb/test_wdt_prescaled.sv
module test_wdt_prescaled;
   localparam int BASE = 18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, sleep = 1'b0, we = 1'b0, on = 1'b0, kick = 1'b0;
   logic [2:0] sel = 3'd0;
   logic       timeout, rst_req;

   always #4 clk = ~clk;

   wdt_prescaled #(.BASE_TICKS(BASE), .PRE_W(8), .EN_RST(1'b1)) i_wdt_prescaled (
      .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .sleep_i(sleep),
      .wr_en_i(we), .wr_on_i(on), .wr_sel_i(sel), .wr_kick_i(kick),
      .timeout_o(timeout), .rst_req_o(rst_req)
   );

   typedef struct {
      logic  req;
      logic  tmo;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   int    n_cmp = 0, n_bad = 0, n_fire = 0;
   string cur = "R1";
   bit    done = 1'b0;

   // reference state
   bit     m_en = 1'b1;
   int     m_sel = 0, m_pre = 0, m_cnt = 0;
   bit     m_tmo = 1'b0;

   task automatic step(input bit t, input bit sl, input bit w, input bit o,
                       input int s, input bit k);
      bit kk, ff;
      int mask;
      @(negedge clk);
      tick = t; sleep = sl; we = w; on = o; sel = 3'(s); kick = k;
      kk = w && k;
      ff = 1'b0;
      if (kk) begin
         m_pre = 0; m_cnt = 0;
      end else if (!m_en) begin
         m_pre = 0; m_cnt = 0;
      end else if (t) begin
         mask = (1 << m_sel) - 1;
         if ((m_pre & mask) == mask && m_cnt == BASE - 1) begin
            ff = 1'b1; m_pre = 0; m_cnt = 0;
         end else begin
            if ((m_pre & mask) == mask) m_cnt++;
            m_pre = (m_pre + 1) & 255;
         end
      end
      if (kk) m_tmo = 1'b0;
      else if (ff) m_tmo = 1'b1;
      if (w && !sl) begin
         m_en = o; m_sel = s;
      end
      if (ff) n_fire++;
      exp_q.push_back('{req: ff, tmo: m_tmo, tag: cur});
   endtask

   task automatic idle(input int n, input bit sl);
      for (int i = 0; i < n; i++) step(1'b0, sl, 1'b0, 1'b0, 0, 1'b0);
   endtask

   task automatic ticks(input int n, input int gap, input bit sl);
      for (int i = 0; i < n; i++) begin
         step(1'b1, sl, 1'b0, 1'b0, 0, 1'b0);
         for (int g = 0; g < gap; g++) step(1'b0, sl, 1'b0, 1'b0, 0, 1'b0);
      end
   endtask

   task automatic wr(input bit o, input int s, input bit k, input bit sl);
      step(1'b0, sl, 1'b1, o, s, k);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (rst_req !== e.req || timeout !== e.tmo) begin
               n_bad++;
               $display("FAIL %s: rst_req/timeout actual %b/%b expected %b/%b at %0t",
                        e.tag, rst_req, timeout, e.req, e.tmo, $time);
            end
         end
      end
   end

   // watchdog
   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int f0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: idle after reset
      cur = "R1"; idle(4, 1'b0);
      // R2: code 0, dense ticks, two expiries; R4 restart
      cur = "R2"; ticks(BASE, 0, 1'b0);
      cur = "R4"; ticks(BASE, 0, 1'b0); idle(2, 1'b0);
      // R10: sparse ticks, gaps must not count
      cur = "R10"; wr(1'b1, 0, 1'b1, 1'b0); ticks(BASE + 2, 2, 1'b0);
      // R3: code 3 and code 7
      cur = "R3"; wr(1'b1, 3, 1'b1, 1'b0); ticks(BASE * 8 * 2 + 3, 0, 1'b0);
      f0 = n_fire;
      wr(1'b1, 7, 1'b1, 1'b0); ticks(BASE * 128 * 2 + 3, 0, 1'b0);
      // R6: kick before and exactly at expiry
      cur = "R6"; wr(1'b1, 0, 1'b1, 1'b0);
      ticks(BASE - 1, 0, 1'b0); wr(1'b1, 0, 1'b1, 1'b0);
      ticks(BASE - 1, 0, 1'b0); step(1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b1);
      ticks(BASE - 1, 0, 1'b0); idle(2, 1'b0);
      // R9: timeout sticky then cleared by kick
      cur = "R9"; ticks(1, 0, 1'b0); idle(5, 1'b0); wr(1'b1, 0, 1'b1, 1'b0); idle(2, 1'b0);
      // R5 and R8: writes in sleep ignored, expiry in sleep
      cur = "R8"; wr(1'b0, 5, 1'b0, 1'b1); wr(1'b1, 0, 1'b1, 1'b1);
      cur = "R5"; ticks(BASE * 2, 1, 1'b1); idle(2, 1'b1);
      // R7: disabled, then re-enabled
      cur = "R7"; wr(1'b0, 0, 1'b0, 1'b0); ticks(BASE * 3, 0, 1'b0);
      wr(1'b1, 0, 1'b0, 1'b0); ticks(BASE + 1, 0, 1'b0);
      idle(3, 1'b0);
      // R3: code 7 path must have produced its two expiries
      n_cmp++;
      if (n_fire - f0 < 2) begin
         n_bad++;
         $display("FAIL R3: code-7 expiries actual %0d expected >=2", n_fire - f0);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule